// File: doc/BRIEF.md
# UART Receive FIFO with Per-Character Error Tags

This block is the receive-side character buffer of a classic byte-wide serial port. A receive shifter hands it each assembled character together with that character's parity and framing verdicts, and a break detector hands it a break level. Every stored entry carries its data byte and a small error tag. The tag does not reach the sticky line-status bits when the character arrives. It is merged only once the character reaches the head of the queue, and it is then wiped from the stored entry. As a result, software reading the status flags learns about an error at the moment the offending character is the next one it would read.

The buffer runs either as a single holding register or as a 16-entry queue. A FIFO-control write picks the mode. Changing the mode, or asking for a receive flush, empties the queue. The block drives the head data for a receive-buffer read and keeps the data-ready flag. It holds five sticky status bits that are cleared by a status read. It also runs a character-timeout counter that interrupt logic elsewhere can compare against a threshold.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset the entry count, data-ready, all five sticky status bits and the timeout counter are zero, the read data is zero, and the buffer is in single-entry mode.
- R2: A pushed character keeps only its low 5+`wordLen` data bits and the rest are zeroed. Characters are read out in arrival order, and `rbrData` shows the head byte, or zero while the buffer is empty.
- R3: A push while the count equals the capacity (1 or DEPTH) and no pop is accepted in the same cycle drops the character and leaves the count unchanged. It sets sticky overrun (`lsrErr[0]`) and receiver-error (`lsrErr[4]`) on the next cycle, and data-ready stays set.
- R4: A character's parity flag goes to tag bit 1, its framing flag to tag bit 2, and their OR to tag bit 4. On each clock where the buffer is non-empty, the head entry's tag is ORed into `lsrErr` and then cleared in storage. A tagged character therefore raises no status bit while it waits behind others, and it raises no bit again after a status clear.
- R5: A receive-buffer read removes the head entry only when the buffer is non-empty. Data-ready then stays set if entries remain and clears otherwise. A read of an empty buffer changes nothing.
- R6: A status read clears all five sticky bits on the next cycle. Any bit that is set in that same cycle still ends up set.
- R7: A FIFO-control write sets the mode from `fcrEnable` (16-deep when 1, single-entry when 0). If the mode changes or `fcrRxReset` is 1, the count, the pointers and data-ready clear and any push in that cycle is dropped. The sticky bits are kept.
- R8: While `breakDet` stays high, exactly one entry is inserted, in the first cycle it is high. That entry has zero data and tag bits break (bit 3) and receiver-error (bit 4), and it sets data-ready. A character pushed in that cycle is dropped.
- R9: The timeout counter clears on the cycle after a receive-buffer read or any push attempt. Otherwise it counts up by one for each clock in which data-ready was set, saturating at its maximum.
- R10: A pop and a push in the same cycle on a full buffer keep the count, add the new character at the tail and report no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pushValid | input | 1 | Receive shifter delivers a character this cycle |
| pushData | input | 8 | Delivered character |
| pushParErr | input | 1 | Delivered character failed its parity check |
| pushFrmErr | input | 1 | Delivered character had a bad stop bit |
| breakDet | input | 1 | Break condition present on the line (level) |
| wordLen | input | 2 | Word length code; data width is 5+wordLen bits |
| rbrRead | input | 1 | Receive-buffer read strobe (pops the head) |
| rbrData | output | 8 | Head data byte, zero when empty |
| lsrRead | input | 1 | Status read strobe (clears sticky bits) |
| fcrWrite | input | 1 | FIFO-control write strobe |
| fcrEnable | input | 1 | Mode written with fcrWrite: 1 = 16-deep queue |
| fcrRxReset | input | 1 | Flush request written with fcrWrite |
| dataReady | output | 1 | At least one character is waiting |
| lsrErr | output | 5 | Sticky bits: [0] overrun, [1] parity, [2] framing, [3] break, [4] receiver error |
| rxCount | output | CNT_W | Number of stored entries |
| timeoutCnt | output | TO_W | Clocks elapsed with data waiting since the last read or push |

## Verification
The bench targets the timing of tag merging. A design that merged tags on entry would flag a parity error while clean characters were still ahead of the bad one. A design that failed to strip the tag would raise the bit again after a status clear. It also hits the full-buffer edge with a read in the same cycle, where a careless fullness test reports a false overrun or loses the new character. It checks that a break held for several cycles inserts a single entry. Finally, it checks that a mode change without an explicit flush request still empties the buffer.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;

  // Tag order fixes the status bit positions: ovr is bit 0, rxErr is bit 4.
  typedef struct packed {
    logic rxErr;
    logic brk;
    logic frm;
    logic par;
    logic ovr;
  } errTag_t;

  localparam int TAG_W = $bits(errTag_t);

  typedef struct packed {
    errTag_t           tag;
    logic [DATA_W-1:0] data;
  } rxEntry_t;

  // Strobes from control to the storage datapath.
  typedef struct packed {
    logic wrEn;
    logic wrBreak;
    logic clrHeadTag;
  } dpCmd_t;
endpackage

// File: rtl/rxq_data.sv
module rxq_data
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [DATA_W-1:0] inData,
  input  logic              inPar,
  input  logic              inFrm,
  input  logic [1:0]        wordLen,
  output rxEntry_t          headEntry
);
  logic [DATA_W-1:0] lenMask;
  rxEntry_t          newEntry;
  rxEntry_t          slotArr [DEPTH];

  // 5 + wordLen valid bits: shift an all-ones byte right by 3 - wordLen.
  assign lenMask = 8'hFF >> (2'd3 - wordLen);

  always_comb begin
    newEntry = '0;
    if (cmd.wrBreak) begin
      newEntry.tag.brk   = 1'b1;
      newEntry.tag.rxErr = 1'b1;
    end else begin
      newEntry.data      = inData & lenMask;
      newEntry.tag.par   = inPar;
      newEntry.tag.frm   = inFrm;
      newEntry.tag.rxErr = inPar | inFrm;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : gSlot
      rxEntry_t slotQ;
      logic     wrHit;
      logic     clrHit;

      assign wrHit  = cmd.wrEn && (wrPtr == PTR_W'(g));
      assign clrHit = cmd.clrHeadTag && (rdPtr == PTR_W'(g));

      // A write into the slot being vacated wins over the tag wipe.
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          slotQ <= '0;
        end else if (wrHit) begin
          slotQ <= newEntry;
        end else if (clrHit) begin
          slotQ.tag <= '0;
        end
      end

      assign slotArr[g] = slotQ;
    end
  endgenerate

  assign headEntry = slotArr[rdPtr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4,
  parameter int CNT_W = 5,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic             breakDet,
  input  logic             rbrRead,
  input  logic             lsrRead,
  input  logic             fcrWrite,
  input  logic             fcrEnable,
  input  logic             fcrRxReset,
  input  errTag_t          headTag,
  output dpCmd_t           cmd,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [CNT_W-1:0] count,
  output logic             dataReady,
  output errTag_t          lsrSticky,
  output logic [TO_W-1:0]  timeoutCnt,
  output logic             fifoMode
);
  localparam logic [CNT_W-1:0] CAP_DEEP = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CAP_CHAR = CNT_W'(1);
  localparam logic [TO_W-1:0]  TO_MAX   = '1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic             brkSeen;
  logic [CNT_W-1:0] capacity;
  logic             notEmpty;
  logic             fcrFlush;
  logic             brkEvent;
  logic             pushTry;
  logic             popOk;
  logic             isFull;
  logic             pushOk;
  logic             overrun;
  errTag_t          setTag;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p, input logic deep);
    if (deep && (p != PTR_LAST)) return p + 1'b1;
    return '0;
  endfunction

  always_comb begin
    capacity = fifoMode ? CAP_DEEP : CAP_CHAR;
    notEmpty = (count != '0);
    fcrFlush = fcrWrite && (fcrRxReset || (fcrEnable != fifoMode));
    brkEvent = breakDet && !brkSeen;
    pushTry  = brkEvent || pushValid;
    popOk    = !fcrFlush && rbrRead && notEmpty;
    isFull   = (count == capacity);
    pushOk   = !fcrFlush && pushTry && (!isFull || popOk);
    overrun  = !fcrFlush && pushTry && isFull && !popOk;

    setTag = notEmpty ? headTag : '0;
    if (overrun) begin
      setTag.ovr   = 1'b1;
      setTag.rxErr = 1'b1;
    end

    cmd.wrEn       = pushOk;
    cmd.wrBreak    = brkEvent;
    cmd.clrHeadTag = notEmpty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brkSeen    <= 1'b0;
      fifoMode   <= 1'b0;
      wrPtr      <= '0;
      rdPtr      <= '0;
      count      <= '0;
      dataReady  <= 1'b0;
      lsrSticky  <= '0;
      timeoutCnt <= '0;
    end else begin
      brkSeen <= breakDet;
      if (fcrWrite) fifoMode <= fcrEnable;

      if (fcrFlush) begin
        wrPtr     <= '0;
        rdPtr     <= '0;
        count     <= '0;
        dataReady <= 1'b0;
      end else begin
        if (pushOk) wrPtr <= advance(wrPtr, fifoMode);
        if (popOk)  rdPtr <= advance(rdPtr, fifoMode);
        unique case ({pushOk, popOk})
          2'b10:   count <= count + 1'b1;
          2'b01:   count <= count - 1'b1;
          default: count <= count;
        endcase
        if (pushTry)    dataReady <= 1'b1;
        else if (popOk) dataReady <= (count != CAP_CHAR);
      end

      lsrSticky <= errTag_t'((lsrRead ? '0 : lsrSticky) | setTag);

      if (rbrRead || pushTry)                   timeoutCnt <= '0;
      else if (dataReady && timeoutCnt != TO_MAX) timeoutCnt <= timeoutCnt + 1'b1;
    end
  end
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TO_W  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic [7:0]       pushData,
  input  logic             pushParErr,
  input  logic             pushFrmErr,
  input  logic             breakDet,
  input  logic [1:0]       wordLen,
  input  logic             rbrRead,
  output logic [7:0]       rbrData,
  input  logic             lsrRead,
  input  logic             fcrWrite,
  input  logic             fcrEnable,
  input  logic             fcrRxReset,
  output logic             dataReady,
  output logic [4:0]       lsrErr,
  output logic [CNT_W-1:0] rxCount,
  output logic [TO_W-1:0]  timeoutCnt
);
  dpCmd_t           cmd;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  rxEntry_t         headEntry;
  errTag_t          lsrSticky;
  logic             fifoMode;

  rxq_ctrl #(
    .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W), .TO_W(TO_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pushValid  (pushValid),
    .breakDet   (breakDet),
    .rbrRead    (rbrRead),
    .lsrRead    (lsrRead),
    .fcrWrite   (fcrWrite),
    .fcrEnable  (fcrEnable),
    .fcrRxReset (fcrRxReset),
    .headTag    (headEntry.tag),
    .cmd        (cmd),
    .wrPtr      (wrPtr),
    .rdPtr      (rdPtr),
    .count      (rxCount),
    .dataReady  (dataReady),
    .lsrSticky  (lsrSticky),
    .timeoutCnt (timeoutCnt),
    .fifoMode   (fifoMode)
  );

  rxq_data #(
    .DEPTH(DEPTH), .PTR_W(PTR_W)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .wrPtr     (wrPtr),
    .rdPtr     (rdPtr),
    .inData    (pushData),
    .inPar     (pushParErr),
    .inFrm     (pushFrmErr),
    .wordLen   (wordLen),
    .headEntry (headEntry)
  );

  assign rbrData = (rxCount != '0) ? headEntry.data : '0;
  assign lsrErr  = lsrSticky;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5,
  parameter int TO_W  = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             pushValid,
  input logic             breakDet,
  input logic             rbrRead,
  input logic             fcrWrite,
  input logic             fcrRxReset,
  input logic             fifoMode,
  input logic             dataReady,
  input logic [4:0]       lsrErr,
  input logic [CNT_W-1:0] rxCount,
  input logic [TO_W-1:0]  timeoutCnt
);
  logic [CNT_W-1:0] cap;
  assign cap = fifoMode ? CNT_W'(DEPTH) : CNT_W'(1);

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= cap); // R7

  AST_READY_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    dataReady == (rxCount != '0)); // R5

  AST_OVR_ONLY_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lsrErr[0]) |-> ($past(rxCount) == $past(cap))); // R3

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (fcrWrite && fcrRxReset) |=> (rxCount == '0 && !dataReady)); // R7

  AST_TIMEOUT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    rbrRead |=> (timeoutCnt == '0)); // R9

  AST_POP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (rbrRead && rxCount != '0 && !pushValid && !breakDet && !fcrWrite)
      |=> (rxCount == $past(rxCount) - CNT_W'(1))); // R5

  AST_SWAP_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (rbrRead && pushValid && !breakDet && !fcrWrite && rxCount == cap)
      |=> ($stable(rxCount) && !$rose(lsrErr[0]))); // R10

  AST_BREAK_ONE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(breakDet) && !fcrWrite && !rbrRead && rxCount < cap)
      |=> (rxCount == $past(rxCount) + CNT_W'(1))); // R8
endmodule

bind rx_err_fifo rxq_checker #(
  .DEPTH(DEPTH), .CNT_W(CNT_W), .TO_W(TO_W)
) u_rxqChk (
  .clk        (clk),
  .rstN       (rstN),
  .pushValid  (pushValid),
  .breakDet   (breakDet),
  .rbrRead    (rbrRead),
  .fcrWrite   (fcrWrite),
  .fcrRxReset (fcrRxReset),
  .fifoMode   (fifoMode),
  .dataReady  (dataReady),
  .lsrErr     (lsrErr),
  .rxCount    (rxCount),
  .timeoutCnt (timeoutCnt)
);

// File: tb/test_rx_err_fifo.sv
module test_rx_err_fifo;
  localparam int DEPTH  = 16;
  localparam int TO_W   = 16;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int TO_MAX = (1 << TO_W) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0;
  logic pv = 0, par = 0, frm = 0, bd = 0, rd = 0, lr = 0, fw = 0, fe = 0, fr = 0;
  logic [7:0] pd = 0;
  logic [1:0] wl = 2'd3;

  logic [7:0]       rbrData;
  logic             dataReady;
  logic [4:0]       lsrErr;
  logic [CNT_W-1:0] rxCount;
  logic [TO_W-1:0]  timeoutCnt;

  rx_err_fifo #(.DEPTH(DEPTH), .TO_W(TO_W)) i_rx_err_fifo (
    .clk(clk), .rstN(rstN), .pushValid(pv), .pushData(pd), .pushParErr(par),
    .pushFrmErr(frm), .breakDet(bd), .wordLen(wl), .rbrRead(rd), .rbrData(rbrData),
    .lsrRead(lr), .fcrWrite(fw), .fcrEnable(fe), .fcrRxReset(fr),
    .dataReady(dataReady), .lsrErr(lsrErr), .rxCount(rxCount), .timeoutCnt(timeoutCnt)
  );

  typedef struct {
    logic [7:0] d;
    logic [4:0] e;
  } mEnt_t;

  mEnt_t      mq[$];
  int         mTo = 0;
  logic [4:0] mLsr = 0;
  logic       mDr = 0, mMode = 0, mBrk = 0;

  int    checks = 0, fails = 0;
  string curReq = "R1";
  bit    live = 0;
  bit    done = 0;

  // Reference model variables for one clock step.
  logic [4:0] sv;
  int         pre, cap, msk;
  bit         flush, brkEv, att, pop, oldDr;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mq.delete(); mTo = 0; mLsr = 0; mDr = 0; mMode = 0; mBrk = 0;
    end else begin
      sv    = 5'b0;
      pre   = mq.size();
      cap   = mMode ? DEPTH : 1;
      flush = fw && (fr || (fe != mMode));
      brkEv = bd && !mBrk;
      att   = brkEv || pv;
      oldDr = mDr;
      if (pre > 0) begin
        sv = sv | mq[0].e;
        mq[0].e = 5'b0;
      end
      mBrk = bd;
      pop  = !flush && rd && (pre > 0);
      if (flush) begin
        mq.delete();
        mDr = 0;
      end else begin
        if (pop) void'(mq.pop_front());
        if (att) begin
          if (pre == cap && !pop) sv = sv | 5'b10001;
          else if (brkEv) mq.push_back('{8'h00, 5'b11000});
          else begin
            msk = (1 << (5 + wl)) - 1;
            mq.push_back('{pd & msk[7:0], {par | frm, 1'b0, frm, par, 1'b0}});
          end
          mDr = 1;
        end else if (pop) begin
          mDr = (mq.size() > 0);
        end
      end
      if (fw) mMode = fe;
      if (rd || att) mTo = 0;
      else if (oldDr && mTo < TO_MAX) mTo++;
      mLsr = (lr ? 5'b0 : mLsr) | sv;
    end
  end

  always @(negedge clk) begin
    if (live && !done) begin
      chk(curReq, "rxCount", 32'(rxCount), 32'(mq.size()));
      chk(curReq, "dataReady", 32'(dataReady), 32'(mDr));
      chk(curReq, "lsrErr", 32'(lsrErr), 32'(mLsr));
      chk(curReq, "timeoutCnt", 32'(timeoutCnt), 32'(mTo));
      chk(curReq, "rbrData", 32'(rbrData), (mq.size() > 0) ? 32'(mq[0].d) : 32'h0);
    end
  end

  task automatic clr();
    pv = 0; rd = 0; lr = 0; fw = 0; fr = 0; par = 0; frm = 0;
  endtask
  task automatic idle(int n);
    repeat (n) begin @(negedge clk); clr(); end
  endtask
  task automatic pushC(logic [7:0] d, logic p, logic f);
    @(negedge clk); clr(); pv = 1; pd = d; par = p; frm = f;
  endtask
  task automatic pushRead(logic [7:0] d);
    @(negedge clk); clr(); pv = 1; pd = d; rd = 1;
  endtask
  task automatic readR();
    @(negedge clk); clr(); rd = 1;
  endtask
  task automatic readL();
    @(negedge clk); clr(); lr = 1;
  endtask
  task automatic fcr(logic en, logic rst);
    @(negedge clk); clr(); fw = 1; fe = en; fr = rst;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    live = 1;
    // R1 reset state
    chk("R1", "rxCount", 32'(rxCount), 0);
    chk("R1", "dataReady", 32'(dataReady), 0);
    chk("R1", "lsrErr", 32'(lsrErr), 0);
    chk("R1", "timeoutCnt", 32'(timeoutCnt), 0);
    chk("R1", "rbrData", 32'(rbrData), 0);

    // R2 word-length masking in single-entry mode
    curReq = "R2";
    wl = 2'd0; pushC(8'hFF, 0, 0); idle(1);
    chk("R2", "masked 5-bit", 32'(rbrData), 32'h1F);
    readR(); wl = 2'd3; pushC(8'hA5, 0, 0); idle(1);
    chk("R2", "8-bit data", 32'(rbrData), 32'hA5);
    readR(); idle(1);

    // R5 read of empty buffer
    curReq = "R5";
    readR(); idle(1);
    chk("R5", "empty count", 32'(rxCount), 0);
    chk("R5", "empty ready", 32'(dataReady), 0);

    // R3 overrun in single-entry mode
    curReq = "R3";
    pushC(8'h41, 0, 0); pushC(8'h42, 0, 0); idle(1);
    chk("R3", "overrun+rxErr", 32'(lsrErr), 32'h11);
    chk("R3", "kept first", 32'(rbrData), 32'h41);
    chk("R3", "ready kept", 32'(dataReady), 1);
    // R6 status read clears
    curReq = "R6";
    readL(); idle(1);
    chk("R6", "cleared", 32'(lsrErr), 0);

    // R7 mode change flushes without reset request
    curReq = "R7";
    fcr(1'b1, 1'b0); idle(1);
    chk("R7", "mode flush count", 32'(rxCount), 0);
    for (int i = 0; i < DEPTH; i++) pushC(8'(i + 16), 0, 0);
    idle(1);
    chk("R7", "deep fill", 32'(rxCount), DEPTH);
    readL(); idle(1);

    // R10 swap at full
    curReq = "R10";
    pushRead(8'h77); idle(1);
    chk("R10", "count kept", 32'(rxCount), DEPTH);
    chk("R10", "no overrun", 32'(lsrErr[0]), 0);
    curReq = "R3";
    pushC(8'h78, 0, 0); idle(1);
    chk("R3", "deep overrun", 32'(lsrErr[0]), 1);
    curReq = "R7";
    fcr(1'b1, 1'b1); idle(1);
    chk("R7", "flush count", 32'(rxCount), 0);
    chk("R7", "sticky kept", 32'(lsrErr[0]), 1);
    readL(); idle(1);

    // R4 tag reaches status only at head
    curReq = "R4";
    pushC(8'h01, 0, 0); pushC(8'h02, 0, 0); pushC(8'h03, 1, 0); pushC(8'h04, 0, 1);
    readL(); idle(2);
    chk("R4", "parity hidden", 32'(lsrErr[1]), 0);
    readR(); readR(); idle(2);
    chk("R4", "parity at head", 32'(lsrErr[1]), 1);
    chk("R4", "head byte", 32'(rbrData), 32'h03);
    readL(); idle(2);
    chk("R4", "stripped", 32'(lsrErr), 0);
    readR(); idle(2);
    chk("R4", "framing at head", 32'(lsrErr[2]), 1);
    readR(); readL(); idle(1);

    // R8 break held several cycles gives one entry
    curReq = "R8";
    @(negedge clk); clr(); bd = 1; pv = 1; pd = 8'h55;
    idle(4);
    bd = 0; idle(1);
    chk("R8", "one entry", 32'(rxCount), 1);
    chk("R8", "zero data", 32'(rbrData), 0);
    chk("R8", "break tags", 32'(lsrErr), 32'h18);

    // R9 timeout counting and clearing
    curReq = "R9";
    idle(10);
    chk("R9", "counting", 32'(timeoutCnt), 32'(mTo));
    readR(); idle(1);
    chk("R9", "cleared by read", 32'(timeoutCnt), 0);

    // mixed pseudo-random traffic in both modes
    curReq = "R2";
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); clr();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      pv  = lf[0];
      pd  = lf[15:8];
      par = lf[2] & lf[3] & lf[4];
      frm = lf[5] & lf[6] & lf[7];
      rd  = lf[1] & lf[9];
      lr  = lf[10] & lf[11];
      fw  = (lf[14:12] == 3'd0) && lf[3] && lf[8];
      fe  = lf[4] | lf[5];
      fr  = lf[6] & lf[8];
      if (lf[15:12] == 4'hF) wl = lf[1:0];
      if (lf[11:7] == 5'd0) bd = ~bd;
    end
    bd = 0;
    idle(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule